// File: doc/BRIEF.md
# Bit-Serial Program Counter Unit

This block holds the program counter of a small serial processor in a shift register. The full register drives the instruction fetch address in parallel. When the control logic asks for a new PC, the block works through it one bit per cycle, least significant bit first. A single full adder and a carry flop produce each bit. An update always lasts exactly `PC_W` cycles, and the PC is rotated through the register as it is rebuilt.

Four sources can supply the next PC, chosen by a select code that is captured when an update starts:

- **Sequential:** the current PC plus four.
- **Absolute target:** a serial operand, copied in unchanged.
- **Relative offset:** a serial operand, added to the current PC.
- **Trap:** a separate serial stream from the trap and CSR logic.

The block also owns a plain request/acknowledge fetch handshake. It raises a request once reset is released, and again each time an update finishes. It holds the request until the acknowledge is seen. While a request is outstanding the PC does not move.

Top module: `pcu_serial_pc`

## Requirements
- R1: While `rst` is high, `fetch_addr` equals the parameter `RESET_VEC` (default 0), `fetch_req` is low and `upd_busy` is low.
- R2: At the first rising clock edge with `rst` low, `fetch_req` goes high.
- R3: `fetch_req` stays high until a rising edge at which `fetch_ack` is high. After that edge it is low.
- R4: With `upd_sel` = 0 (sequential), the updated PC is the old PC plus 4, modulo 2^PC_W. 0xFFFFFFFC wraps to 0.
- R5: With `upd_sel` = 1 (absolute), the updated PC equals the `PC_W` bits presented on `opnd_bit`. `trap_bit` has no effect.
- R6: With `upd_sel` = 2 (relative), the updated PC is the old PC plus the `opnd_bit` word, modulo 2^PC_W. A two's-complement word moves the PC backwards.
- R7: With `upd_sel` = 3 (trap), the updated PC equals the word presented on `trap_bit`. `opnd_bit` has no effect.
- R8: An update starts at an edge where `upd_start` is accepted. Bit k of each serial stream is sampled at the (k+1)-th edge after that, LSB first. `upd_busy` is high for exactly `PC_W` cycles, and `fetch_req` rises at the edge at which `upd_busy` falls.
- R9: `upd_start` is ignored while `upd_busy` or `fetch_req` is high. The PC is unchanged while a fetch request is outstanding.
- R10: The adder carry is cleared at the start of every update, so a carry out of the top bit in one update does not leak into the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| upd_start | input | 1 | Request to begin a serial PC update |
| upd_sel | input | 2 | Next-PC source: 0 sequential, 1 absolute, 2 relative, 3 trap |
| opnd_bit | input | 1 | Serial target or offset bit, LSB first |
| trap_bit | input | 1 | Serial trap/CSR PC bit, LSB first |
| upd_busy | output | 1 | High while the serial update runs |
| fetch_req | output | 1 | Instruction fetch request (bus cycle) |
| fetch_ack | input | 1 | Instruction fetch acknowledge |
| fetch_addr | output | PC_W | Parallel PC used as fetch address |

## Verification
The assertions assume the following about the inputs:

- `fetch_ack` is only meaningful while `fetch_req` is high.
- The surrounding control presents `upd_start` only when it intends to begin an update.
- The serial bits arrive one per cycle for exactly the update window.

The stimulus keeps to these assumptions. It raises `fetch_ack` only after it has seen a request and holds it for a single cycle. It drives every serial bit on the falling edge before the rising edge that samples it. The only out-of-protocol `upd_start` pulses are deliberate ones, issued mid-update or during an outstanding request, to show they are ignored.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  typedef enum logic [1:0] {
    SRC_SEQ  = 2'd0,
    SRC_ABS  = 2'd1,
    SRC_REL  = 2'd2,
    SRC_TRAP = 2'd3
  } pc_src_e;

  // One-bit full adder: sum output
  function automatic logic fa_sum(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  // One-bit full adder: carry output
  function automatic logic fa_carry(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // Serial addend for the sequential source: a single 1 at the increment position
  function automatic logic inc_addend(input int unsigned idx, input int unsigned pos);
    return (idx == pos);
  endfunction

endpackage

// File: rtl/pcu_sequencer.sv
module pcu_sequencer
  import pcu_pkg::*;
#(
  parameter int unsigned PC_W = 32,
  localparam int unsigned CW = (PC_W > 1) ? $clog2(PC_W) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          hold,
  input  pc_src_e       sel_in,
  output logic          busy,
  output logic          accept,
  output logic          done,
  output logic [CW-1:0] bit_idx,
  output pc_src_e       src
);

  localparam logic [CW-1:0] LAST = CW'(PC_W - 1);

  logic          busy_q;
  logic [CW-1:0] idx_q;
  pc_src_e       src_q;

  assign accept  = start && !busy_q && !hold;
  assign done    = busy_q && (idx_q == LAST);
  assign busy    = busy_q;
  assign bit_idx = idx_q;
  assign src     = src_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      src_q  <= SRC_SEQ;
    end else if (accept) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      src_q  <= sel_in;
    end else if (busy_q) begin
      if (idx_q == LAST) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  // R8: an accepted start opens the update window
  a_r8_start_opens: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy && (bit_idx == '0));

  // R8: the bit index advances by one each cycle inside the window
  a_r8_index_steps: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy && (bit_idx == $past(bit_idx) + 1'b1));

  // R8: the window closes after the last bit
  a_r8_window_closes: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);

  // R9: the source does not change during an update
  a_r9_src_locked: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> $stable(src));

endmodule

// File: rtl/pcu_serial_alu.sv
module pcu_serial_alu
  import pcu_pkg::*;
#(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned INC_POS = 2,
  localparam int unsigned CW = (PC_W > 1) ? $clog2(PC_W) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  input  pc_src_e       src,
  input  logic [CW-1:0] bit_idx,
  input  logic          pc_lsb,
  input  logic          opnd_bit,
  input  logic          trap_bit,
  output logic          new_bit,
  output logic          carry
);

  logic carry_q;
  logic add_a;
  logic add_b;
  logic carry_nx;

  always_comb begin
    add_a    = 1'b0;
    add_b    = 1'b0;
    new_bit  = 1'b0;
    carry_nx = 1'b0;
    unique case (src)
      SRC_SEQ: begin
        add_a    = pc_lsb;
        add_b    = inc_addend(int'(bit_idx), INC_POS);
        new_bit  = fa_sum(add_a, add_b, carry_q);
        carry_nx = fa_carry(add_a, add_b, carry_q);
      end
      SRC_REL: begin
        add_a    = pc_lsb;
        add_b    = opnd_bit;
        new_bit  = fa_sum(add_a, add_b, carry_q);
        carry_nx = fa_carry(add_a, add_b, carry_q);
      end
      SRC_ABS:  new_bit = opnd_bit;
      SRC_TRAP: new_bit = trap_bit;
      default:  new_bit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clr) carry_q <= 1'b0;
    else if (step)  carry_q <= carry_nx;
  end

  assign carry = carry_q;

  // R5/R7: copy sources never build up a carry
  a_r5_copy_no_carry: assert property (@(posedge clk) disable iff (rst)
    (step && (src == SRC_ABS || src == SRC_TRAP) && !clr) |=> !carry);

endmodule

// File: rtl/pcu_fetch.sv
module pcu_fetch (
  input  logic clk,
  input  logic rst,
  input  logic launch,
  input  logic ack,
  output logic req,
  output logic boot
);

  logic req_q;
  logic boot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      boot_q <= 1'b1;
    end else if (boot_q) begin
      req_q  <= 1'b1;
      boot_q <= 1'b0;
    end else if (launch) begin
      req_q <= 1'b1;
    end else if (ack) begin
      req_q <= 1'b0;
    end
  end

  assign req  = req_q;
  assign boot = boot_q;

  // R2: first edge out of reset raises the request
  a_r2_boot_fetch: assert property (@(posedge clk) disable iff (rst)
    boot |=> req);

  // R3: request held until acknowledged
  a_r3_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    (req && !ack) |=> req);

  // R3: acknowledge retires the request
  a_r3_ack_drops: assert property (@(posedge clk) disable iff (rst)
    (req && ack && !launch) |=> !req);

endmodule

// File: rtl/pcu_serial_pc.sv
module pcu_serial_pc
  import pcu_pkg::*;
#(
  parameter int unsigned     PC_W      = 32,
  parameter logic [PC_W-1:0] RESET_VEC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            upd_start,
  input  logic [1:0]      upd_sel,
  input  logic            opnd_bit,
  input  logic            trap_bit,
  output logic            upd_busy,
  output logic            fetch_req,
  input  logic            fetch_ack,
  output logic [PC_W-1:0] fetch_addr
);

  localparam int unsigned CW      = (PC_W > 1) ? $clog2(PC_W) : 1;
  localparam int unsigned INC_POS = 2;

  logic [PC_W-1:0] pc_q;
  logic            busy;
  logic            accept;
  logic            done;
  logic [CW-1:0]   bit_idx;
  pc_src_e         src;
  logic            new_bit;
  logic            carry;
  logic            req;
  logic            boot;
  logic            hold;

  assign hold = req | boot;

  pcu_sequencer #(.PC_W(PC_W)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (upd_start),
    .hold    (hold),
    .sel_in  (pc_src_e'(upd_sel)),
    .busy    (busy),
    .accept  (accept),
    .done    (done),
    .bit_idx (bit_idx),
    .src     (src)
  );

  pcu_serial_alu #(.PC_W(PC_W), .INC_POS(INC_POS)) u_alu (
    .clk      (clk),
    .rst      (rst),
    .clr      (accept),
    .step     (busy),
    .src      (src),
    .bit_idx  (bit_idx),
    .pc_lsb   (pc_q[0]),
    .opnd_bit (opnd_bit),
    .trap_bit (trap_bit),
    .new_bit  (new_bit),
    .carry    (carry)
  );

  pcu_fetch u_fetch (
    .clk    (clk),
    .rst    (rst),
    .launch (done),
    .ack    (fetch_ack),
    .req    (req),
    .boot   (boot)
  );

  generate
    if (PC_W > 1) begin : g_shift
      always_ff @(posedge clk) begin
        if (rst)       pc_q <= RESET_VEC;
        else if (busy) pc_q <= {new_bit, pc_q[PC_W-1:1]};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst)       pc_q <= RESET_VEC;
        else if (busy) pc_q <= new_bit;
      end
    end
  endgenerate

  assign fetch_addr = pc_q;
  assign upd_busy   = busy;
  assign fetch_req  = req;

  // R9: PC frozen while a fetch is outstanding
  a_r9_pc_frozen: assert property (@(posedge clk) disable iff (rst)
    req |=> $stable(fetch_addr));

  // R9: never updating and fetching at once
  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(busy && req));

  // R8: completion launches a fetch
  a_r8_done_fetch: assert property (@(posedge clk) disable iff (rst)
    done |=> req && !busy);

  // R10: a fresh update starts with a clear carry
  a_r10_carry_fresh: assert property (@(posedge clk) disable iff (rst)
    accept |=> !carry);

endmodule

// File: tb/sim_pcu_serial_pc.sv
module sim_pcu_serial_pc;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned W          = 32;
  localparam logic [W-1:0] RST_VEC   = 32'h0000_0000;
  localparam int unsigned NV         = 13;

  localparam logic [1:0] V_SEL [NV] = '{
    2'd0, 2'd0, 2'd1, 2'd0, 2'd0, 2'd2, 2'd2, 2'd3, 2'd2, 2'd2, 2'd1, 2'd0, 2'd3
  };
  localparam logic [W-1:0] V_OPR [NV] = '{
    32'h0, 32'h0, 32'hFFFF_FFF8, 32'h0, 32'h0, 32'h0000_1000, 32'hFFFF_FFF0,
    32'h8000_0004, 32'h8000_0000, 32'h0, 32'hA5A5_A5A4, 32'h0, 32'h0000_0100
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         upd_start = 1'b0;
  logic [1:0]   upd_sel = 2'd0;
  logic         opnd_bit = 1'b0;
  logic         trap_bit = 1'b0;
  logic         upd_busy;
  logic         fetch_req;
  logic         fetch_ack = 1'b0;
  logic [W-1:0] fetch_addr;

  int n_chk  = 0;
  int n_fail = 0;
  logic [W-1:0] model_pc;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcu_serial_pc #(.PC_W(W), .RESET_VEC(RST_VEC)) u0 (
    .clk(clk), .rst(rst), .upd_start(upd_start), .upd_sel(upd_sel),
    .opnd_bit(opnd_bit), .trap_bit(trap_bit), .upd_busy(upd_busy),
    .fetch_req(fetch_req), .fetch_ack(fetch_ack), .fetch_addr(fetch_addr)
  );

  task automatic check(input logic ok, input string req_tag,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req_tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] next_pc(input logic [W-1:0] pc, input logic [1:0] sel,
                                           input logic [W-1:0] opr, input logic [W-1:0] trp);
    case (sel)
      2'd0:    return pc + 32'd4;
      2'd1:    return opr;
      2'd2:    return pc + opr;
      default: return trp;
    endcase
  endfunction

  // Start an update, stream the words in, optionally poke a stray start mid-window
  task automatic run_update(input logic [1:0] sel, input logic [W-1:0] opr,
                            input logic [W-1:0] trp, input logic stray);
    @(negedge clk);
    upd_start = 1'b1;
    upd_sel   = sel;
    @(negedge clk);
    upd_start = 1'b0;
    for (int k = 0; k < W; k++) begin
      opnd_bit = opr[k];
      trap_bit = trp[k];
      if (stray && k == 5) begin
        upd_start = 1'b1;
        upd_sel   = ~sel;
      end else begin
        upd_start = 1'b0;
      end
      if (k == 0 || k == W - 1)
        check(upd_busy == 1'b1, "R8 busy in window", {31'd0, upd_busy}, 32'd1);
      @(negedge clk);
    end
    upd_start = 1'b0;
    check(upd_busy == 1'b0, "R8 busy ends after PC_W cycles", {31'd0, upd_busy}, 32'd0);
    check(fetch_req == 1'b1, "R8 fetch after update", {31'd0, fetch_req}, 32'd1);
  endtask

  task automatic do_ack();
    fetch_ack = 1'b1;
    @(negedge clk);
    fetch_ack = 1'b0;
    check(fetch_req == 1'b0, "R3 request retired by ack", {31'd0, fetch_req}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(fetch_addr == RST_VEC, "R1 reset vector", fetch_addr, RST_VEC);
    check(fetch_req == 1'b0, "R1 no request in reset", {31'd0, fetch_req}, 32'd0);
    check(upd_busy == 1'b0, "R1 idle in reset", {31'd0, upd_busy}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(fetch_req == 1'b1, "R2 fetch after reset release", {31'd0, fetch_req}, 32'd1);
    repeat (3) @(negedge clk);
    check(fetch_req == 1'b1, "R3 request held without ack", {31'd0, fetch_req}, 32'd1);

    // R9: start while the request is outstanding is ignored
    upd_start = 1'b1;
    upd_sel   = 2'd1;
    opnd_bit  = 1'b1;
    @(negedge clk);
    upd_start = 1'b0;
    repeat (4) @(negedge clk);
    check(upd_busy == 1'b0, "R9 start ignored during fetch", {31'd0, upd_busy}, 32'd0);
    check(fetch_addr == RST_VEC, "R9 PC unchanged during fetch", fetch_addr, RST_VEC);
    do_ack();
    model_pc = RST_VEC;

    // Vector table: R4 R5 R6 R7 R10
    for (int i = 0; i < NV; i++) begin
      logic [W-1:0] trp;
      logic [W-1:0] opr;
      opr = (V_SEL[i] == 2'd3) ? ~V_OPR[i] : V_OPR[i];
      trp = (V_SEL[i] == 2'd3) ? V_OPR[i] : ~V_OPR[i];
      model_pc = next_pc(model_pc, V_SEL[i], opr, trp);
      run_update(V_SEL[i], opr, trp, 1'b0);
      check(fetch_addr == model_pc, "R4/R5/R6/R7/R10 vector result", fetch_addr, model_pc);
      do_ack();
    end

    // R9: stray start in the middle of an update has no effect
    model_pc = next_pc(model_pc, 2'd2, 32'h0000_0040, 32'h0);
    run_update(2'd2, 32'h0000_0040, 32'hDEAD_BEEF, 1'b1);
    check(fetch_addr == model_pc, "R9 stray start ignored mid-update", fetch_addr, model_pc);
    do_ack();

    // R4 wrap, directed
    model_pc = 32'hFFFF_FFFC;
    run_update(2'd1, 32'hFFFF_FFFC, 32'h0, 1'b0);
    do_ack();
    run_update(2'd0, 32'h0, 32'hFFFF_FFFF, 1'b0);
    check(fetch_addr == 32'h0, "R4 sequential wrap", fetch_addr, 32'h0);
    do_ack();

    // R10: carry out of top bit then relative +0
    run_update(2'd2, 32'hFFFF_FFFF, 32'h0, 1'b0);
    do_ack();
    check(fetch_addr == 32'hFFFF_FFFF, "R6 add with carry chain", fetch_addr, 32'hFFFF_FFFF);
    run_update(2'd2, 32'h0000_0001, 32'h0, 1'b0);
    do_ack();
    run_update(2'd2, 32'h0, 32'h0, 1'b0);
    check(fetch_addr == 32'h0, "R10 carry cleared between updates", fetch_addr, 32'h0);
    do_ack();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule